// File: doc/BRIEF.md
# Peripheral Security Attribute Register Bank

This block holds one security attribute bit per peripheral slot and presents it as a parallel vector to the traffic-filtering logic elsewhere on the chip. A bit value of 1 marks the peripheral as secure; 0 marks it as non-secure. Software programs the bits over a simple 32-bit register bus. Each transfer carries an address, write data, byte strobes, and two attribute signals: one says the master is secure and one says it is privileged. The block returns read data and a one-cycle error response.

Writes are checked bit by bit. Only secure masters may change anything. A second register in the bank, the lock register, holds one bit per peripheral slot. When a slot's lock bit is set, only a secure privileged master may change that slot's security bit. Unprivileged secure code can still change the unlocked slots in the same write. Non-secure write attempts leave a sticky flag set, which a secure privileged master can clear. Reads are open to every master.

Top module: `secattr_bank`

## Requirements
- R1: After reset, the security register, the lock register, the sticky flag, `bus_err` and `sec_vec` are all zero.
- R2: A write with `bus_secure`=0 to any mapped offset (0x014, 0x020, 0x024) changes no register bit. It asserts `bus_err` in the following cycle and sets `illegal_flag`.
- R3: A secure full-word write to the security register at 0x014 updates every implemented bit whose lock bit is 0, whatever the value of `bus_priv`.
- R4: A secure write with `bus_priv`=0 to 0x014 leaves every bit whose lock bit is 1 unchanged, and still updates the unlocked implemented bits.
- R5: Reads are unrestricted. While `bus_sel`=1 and `bus_wr`=0, `bus_rdata` shows the addressed value in the same cycle for any secure/privileged combination. The map is 0x014 for the security register, 0x020 for the lock register, and 0x024 for the status register with the sticky flag in bit 0. Any other address reads zero.
- R6: A secure write to a mapped offset with any `bus_strb` bit at 0 changes nothing. It asserts `bus_err` for exactly one cycle, in the following cycle, and does not set the sticky flag.
- R7: Only the bit positions in `IMPL_MASK` (default 16, 15 to 7, 4, 3 and 1) are writable. Bits 0, 2, 5, 6 and 31 to 17 always read zero in both registers.
- R8: The lock register at 0x020 is updated only by secure privileged full-word writes. A secure unprivileged write to it is ignored without an error.
- R9: The sticky flag stays set until a secure privileged full-word write to 0x024 with data bit 0 = 1 clears it. No other write clears it.
- R10: A new security register value appears on `sec_vec` and in read data from the clock edge that accepts the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | Transfer valid this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_strb | input | 4 | Byte strobes; all ones for a word access |
| bus_secure | input | 1 | Transfer comes from a secure master |
| bus_priv | input | 1 | Transfer comes from privileged code |
| bus_rdata | output | 32 | Read data, valid in the cycle of the read |
| bus_err | output | 1 | One-cycle error response, the cycle after a faulting write |
| sec_vec | output | NUM_ATTR | Per-peripheral security attribute, 1 = secure |
| illegal_flag | output | 1 | Sticky record of a non-secure write attempt |

## Verification
The block has no internal state that the ports do not show. `sec_vec` mirrors the security register directly, so a bit written wrongly, or kept when it should have changed, shows one clock edge after the faulty write. A corrupted lock bit stays hidden until a later unprivileged write touches that slot and the slot changes or holds against expectation; a read of 0x020 exposes it at once. A wrong error decision shows on `bus_err` in the cycle after the write, and a mishandled sticky flag shows on `illegal_flag` at that same edge.

// File: rtl/secattr_pkg.sv
// Shared definitions for the peripheral security attribute bank.
// Assumes a 32-bit register bus with byte strobes.
package secattr_pkg;
    localparam int unsigned BUS_W  = 32;
    localparam int unsigned STRB_W = BUS_W / 8;

    // Which register of the bank an address selects
    typedef enum logic [1:0] {
        REG_NONE = 2'd0,
        REG_SEC  = 2'd1,
        REG_LOCK = 2'd2,
        REG_STAT = 2'd3
    } reg_pick_e;

    // Reasons a write is refused with an error response
    typedef struct packed {
        logic nonsec;
        logic width;
    } fault_t;
endpackage

// File: rtl/secattr_decode.sv
// Address decoder: maps a byte address to one register of the bank.
// Assumes exact, word-aligned offsets; any other address selects nothing.
module secattr_decode
    import secattr_pkg::*;
#(
    parameter int unsigned    ADDR_W   = 12,
    parameter logic [ADDR_W-1:0] SEC_OFS  = 12'h014,
    parameter logic [ADDR_W-1:0] LOCK_OFS = 12'h020,
    parameter logic [ADDR_W-1:0] STAT_OFS = 12'h024
) (
    input  logic [ADDR_W-1:0] addr,
    output reg_pick_e         pick
);
    // Compare the address with each mapped offset
    always_comb begin
        if (addr == SEC_OFS)       pick = REG_SEC;
        else if (addr == LOCK_OFS) pick = REG_LOCK;
        else if (addr == STAT_OFS) pick = REG_STAT;
        else                       pick = REG_NONE;
    end
endmodule

// File: rtl/secattr_access_chk.sv
// Access checker: turns one bus write into per-bit write enables, a flag
// clear request and fault indications.
// Assumes one transfer per cycle; reads never fault.
module secattr_access_chk
    import secattr_pkg::*;
#(
    parameter int unsigned        NUM_ATTR  = 17,
    parameter logic [NUM_ATTR-1:0] IMPL_MASK = 17'h1FF9A
) (
    input  logic                bus_sel,
    input  logic                bus_wr,
    input  logic [STRB_W-1:0]   bus_strb,
    input  logic                bus_secure,
    input  logic                bus_priv,
    input  logic                clr_bit,
    input  reg_pick_e           pick,
    input  logic [NUM_ATTR-1:0] lock_q,
    output logic [NUM_ATTR-1:0] sec_wmask,
    output logic [NUM_ATTR-1:0] lock_wmask,
    output logic                flag_clr,
    output fault_t              fault
);
    logic wr_req;
    logic word_ok;
    logic accept;
    logic [NUM_ATTR-1:0] allow;

    // Classify the write and build the per-bit enables
    always_comb begin
        wr_req       = bus_sel & bus_wr & (pick != REG_NONE);
        word_ok      = &bus_strb;
        fault.nonsec = wr_req & ~bus_secure;
        fault.width  = wr_req & bus_secure & ~word_ok;
        accept       = wr_req & bus_secure & word_ok;
        allow        = bus_priv ? IMPL_MASK : (IMPL_MASK & ~lock_q);
        sec_wmask    = (accept && pick == REG_SEC) ? allow : '0;
        lock_wmask   = (accept && bus_priv && pick == REG_LOCK) ? IMPL_MASK : '0;
        flag_clr     = accept & bus_priv & (pick == REG_STAT) & clr_bit;
    end
endmodule

// File: rtl/secattr_bitreg.sv
// Attribute register with an independent write enable per bit.
// Assumes the caller keeps the enables of unimplemented bits at zero.
module secattr_bitreg #(
    parameter int unsigned W = 17
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] wmask,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] q
);
    for (genvar i = 0; i < W; i++) begin : g_bit
        // One flop per attribute, loaded only when its enable is high
        always_ff @(posedge clk) begin
            if (!rst_n)        q[i] <= 1'b0;
            else if (wmask[i]) q[i] <= wdata[i];
        end
    end
endmodule

// File: rtl/secattr_bank.sv
// Peripheral security attribute bank: a security register, a lock register
// and a status register on a 32-bit register bus, plus the parallel vector.
// Assumes read data is taken in the cycle of the read, and an error is
// answered one cycle after the faulting write.
module secattr_bank
    import secattr_pkg::*;
#(
    parameter int unsigned         ADDR_W    = 12,
    parameter int unsigned         NUM_ATTR  = 17,
    parameter logic [NUM_ATTR-1:0] IMPL_MASK = 17'h1FF9A,
    parameter logic [ADDR_W-1:0]   SEC_OFS   = 12'h014,
    parameter logic [ADDR_W-1:0]   LOCK_OFS  = 12'h020,
    parameter logic [ADDR_W-1:0]   STAT_OFS  = 12'h024
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bus_sel,
    input  logic                bus_wr,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [31:0]         bus_wdata,
    input  logic [3:0]          bus_strb,
    input  logic                bus_secure,
    input  logic                bus_priv,
    output logic [31:0]         bus_rdata,
    output logic                bus_err,
    output logic [NUM_ATTR-1:0] sec_vec,
    output logic                illegal_flag
);
    localparam int unsigned PAD_W = BUS_W - NUM_ATTR;

    reg_pick_e           pick;
    logic [NUM_ATTR-1:0] sec_q;
    logic [NUM_ATTR-1:0] lock_q;
    logic [NUM_ATTR-1:0] sec_wmask;
    logic [NUM_ATTR-1:0] lock_wmask;
    logic                flag_clr;
    fault_t              fault;
    logic                flag_q;
    logic                err_q;
    logic                unused_wdata;

    assign unused_wdata = ^bus_wdata[BUS_W-1:NUM_ATTR];

    secattr_decode #(
        .ADDR_W(ADDR_W), .SEC_OFS(SEC_OFS),
        .LOCK_OFS(LOCK_OFS), .STAT_OFS(STAT_OFS)
    ) dec_i (
        .addr(bus_addr),
        .pick(pick)
    );

    secattr_access_chk #(
        .NUM_ATTR(NUM_ATTR), .IMPL_MASK(IMPL_MASK)
    ) chk_i (
        .bus_sel(bus_sel),
        .bus_wr(bus_wr),
        .bus_strb(bus_strb),
        .bus_secure(bus_secure),
        .bus_priv(bus_priv),
        .clr_bit(bus_wdata[0]),
        .pick(pick),
        .lock_q(lock_q),
        .sec_wmask(sec_wmask),
        .lock_wmask(lock_wmask),
        .flag_clr(flag_clr),
        .fault(fault)
    );

    secattr_bitreg #(.W(NUM_ATTR)) sec_reg_i (
        .clk(clk), .rst_n(rst_n),
        .wmask(sec_wmask), .wdata(bus_wdata[NUM_ATTR-1:0]),
        .q(sec_q)
    );

    secattr_bitreg #(.W(NUM_ATTR)) lock_reg_i (
        .clk(clk), .rst_n(rst_n),
        .wmask(lock_wmask), .wdata(bus_wdata[NUM_ATTR-1:0]),
        .q(lock_q)
    );

    // Sticky record of non-secure write attempts; setting wins over clearing
    always_ff @(posedge clk) begin
        if (!rst_n)            flag_q <= 1'b0;
        else if (fault.nonsec) flag_q <= 1'b1;
        else if (flag_clr)     flag_q <= 1'b0;
    end

    // One-cycle error response for any refused write
    always_ff @(posedge clk) begin
        if (!rst_n) err_q <= 1'b0;
        else        err_q <= fault.nonsec | fault.width;
    end

    // Read data multiplexer, open to every master
    always_comb begin
        bus_rdata = '0;
        if (bus_sel && !bus_wr) begin
            case (pick)
                REG_SEC:  bus_rdata = {{PAD_W{1'b0}}, sec_q};
                REG_LOCK: bus_rdata = {{PAD_W{1'b0}}, lock_q};
                REG_STAT: bus_rdata = {{(BUS_W-1){1'b0}}, flag_q};
                default:  bus_rdata = '0;
            endcase
        end
    end

    assign bus_err      = err_q;
    assign sec_vec      = sec_q;
    assign illegal_flag = flag_q;
endmodule

// File: rtl/secattr_bank_chk.sv
// Assertion checker for the security attribute bank, bound to the top.
// Assumes the same parameters as the top it is bound to.
module secattr_bank_chk #(
    parameter int unsigned         ADDR_W    = 12,
    parameter int unsigned         NUM_ATTR  = 17,
    parameter logic [NUM_ATTR-1:0] IMPL_MASK = 17'h1FF9A,
    parameter logic [ADDR_W-1:0]   SEC_OFS   = 12'h014,
    parameter logic [ADDR_W-1:0]   LOCK_OFS  = 12'h020,
    parameter logic [ADDR_W-1:0]   STAT_OFS  = 12'h024
) (
    input logic                clk,
    input logic                rst_n,
    input logic                bus_sel,
    input logic                bus_wr,
    input logic [ADDR_W-1:0]   bus_addr,
    input logic [31:0]         bus_wdata,
    input logic [3:0]          bus_strb,
    input logic                bus_secure,
    input logic                bus_priv,
    input logic                bus_err,
    input logic [NUM_ATTR-1:0] sec_vec,
    input logic [NUM_ATTR-1:0] lock_q,
    input logic                illegal_flag
);
    logic mapped;
    logic wr_now;
    assign mapped = (bus_addr == SEC_OFS) || (bus_addr == LOCK_OFS) || (bus_addr == STAT_OFS);
    assign wr_now = bus_sel && bus_wr;

    p_nonsec_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_now && !bus_secure |=> $stable(sec_vec) && $stable(lock_q));

    p_nonsec_err_r2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_now && !bus_secure && mapped |=> bus_err && illegal_flag);

    p_locked_keep_r4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_now && bus_secure && !bus_priv |=>
            ((sec_vec ^ $past(sec_vec)) & $past(lock_q)) == '0);

    p_partial_ignored_r6: assert property (@(posedge clk) disable iff (!rst_n)
        wr_now && bus_strb != 4'hF |=> $stable(sec_vec) && $stable(lock_q));

    p_partial_err_r6: assert property (@(posedge clk) disable iff (!rst_n)
        wr_now && bus_secure && bus_strb != 4'hF && mapped |=> bus_err);

    p_reserved_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ((sec_vec | lock_q) & ~IMPL_MASK) == '0);

    p_lock_guard_r8: assert property (@(posedge clk) disable iff (!rst_n)
        wr_now && !(bus_secure && bus_priv) |=> $stable(lock_q));

    p_flag_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        illegal_flag && !(wr_now && bus_secure && bus_priv && bus_strb == 4'hF
                          && bus_addr == STAT_OFS && bus_wdata[0]) |=> illegal_flag);
endmodule

bind secattr_bank secattr_bank_chk #(
    .ADDR_W(ADDR_W), .NUM_ATTR(NUM_ATTR), .IMPL_MASK(IMPL_MASK),
    .SEC_OFS(SEC_OFS), .LOCK_OFS(LOCK_OFS), .STAT_OFS(STAT_OFS)
) sva_i (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_strb(bus_strb),
    .bus_secure(bus_secure), .bus_priv(bus_priv), .bus_err(bus_err),
    .sec_vec(sec_vec), .lock_q(lock_q), .illegal_flag(illegal_flag)
);

// File: tb/secattr_bank_tb_top.sv
`timescale 1ns/1ps
module secattr_bank_tb_top;
    localparam logic [16:0] IMPL = 17'h1FF9A;
    localparam logic [11:0] A_SEC = 12'h014, A_LOCK = 12'h020, A_STAT = 12'h024, A_HOLE = 12'h018;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0, bus_wr = 1'b0, bus_secure = 1'b0, bus_priv = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [3:0]  bus_strb = '0;
    logic [31:0] bus_rdata;
    logic        bus_err;
    logic [16:0] sec_vec;
    logic        illegal_flag;

    int unsigned n_vec = 0, n_bad = 0;
    logic [16:0] m_sec = '0, m_lock = '0;
    logic        m_flag = 1'b0, m_err = 1'b0;

    always #2.5 clk = ~clk;

    secattr_bank dut_i (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_strb(bus_strb),
        .bus_secure(bus_secure), .bus_priv(bus_priv), .bus_rdata(bus_rdata),
        .bus_err(bus_err), .sec_vec(sec_vec), .illegal_flag(illegal_flag)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic bit is_mapped(input logic [11:0] a);
        return a == A_SEC || a == A_LOCK || a == A_STAT;
    endfunction

    // Update the bench's expected state from the requirement text
    task automatic model_write(input logic [11:0] a, input logic [31:0] d,
                               input logic [3:0] s, input logic sec, input logic prv);
        logic [16:0] allow;
        m_err = 1'b0;
        if (!is_mapped(a)) return;
        if (!sec) begin m_flag = 1'b1; m_err = 1'b1; return; end   // R2
        if (s != 4'hF) begin m_err = 1'b1; return; end             // R6
        allow = prv ? IMPL : (IMPL & ~m_lock);                     // R3 R4 R7
        if (a == A_SEC) m_sec = (m_sec & ~allow) | (d[16:0] & allow);
        else if (a == A_LOCK) begin if (prv) m_lock = d[16:0] & IMPL; end  // R8
        else if (prv && d[0]) m_flag = 1'b0;                       // R9
    endtask

    task automatic do_write(input string req, input logic [11:0] a, input logic [31:0] d,
                            input logic [3:0] s, input logic sec, input logic prv);
        @(negedge clk);
        bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
        bus_strb = s; bus_secure = sec; bus_priv = prv;
        @(negedge clk);
        bus_sel = 0; bus_wr = 0;
        model_write(a, d, s, sec, prv);
        check({req, " R10 sec_vec"}, {15'b0, sec_vec}, {15'b0, m_sec});
        check({req, " err"}, {31'b0, bus_err}, {31'b0, m_err});
        check({req, " flag"}, {31'b0, illegal_flag}, {31'b0, m_flag});
        if (m_err) begin
            @(negedge clk);
            check({req, " R6 err one cycle"}, {31'b0, bus_err}, 32'b0);
        end
    endtask

    task automatic do_read(input string req, input logic [11:0] a, input logic sec, input logic prv);
        logic [31:0] exp;
        @(negedge clk);
        bus_sel = 1; bus_wr = 0; bus_addr = a; bus_secure = sec; bus_priv = prv;
        #1;
        if (a == A_SEC) exp = {15'b0, m_sec};
        else if (a == A_LOCK) exp = {15'b0, m_lock};
        else if (a == A_STAT) exp = {31'b0, m_flag};
        else exp = '0;
        check({req, " R5 read"}, bus_rdata, exp);
        @(negedge clk);
        bus_sel = 0;
    endtask

    initial begin
        #(5.0 * 150000);
        n_bad++;
        $display("FAIL watchdog: actual running expected finished");
        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 sec_vec", {15'b0, sec_vec}, 32'b0);
        check("R1 err", {31'b0, bus_err}, 32'b0);
        check("R1 flag", {31'b0, illegal_flag}, 32'b0);
        do_read("R1 sec", A_SEC, 1, 1);
        do_read("R1 lock", A_LOCK, 1, 1);
        do_read("R1 stat", A_STAT, 1, 1);

        // R3 and R7: unprivileged secure write with no locks sets all implemented bits
        do_write("R3 R7 unpriv all", A_SEC, 32'hFFFF_FFFF, 4'hF, 1, 0);
        do_read("R7 reserved zero", A_SEC, 0, 0);
        do_read("R5 nonsec read", A_SEC, 0, 1);
        // R8: unprivileged lock write ignored, privileged accepted
        do_write("R8 unpriv lock", A_LOCK, 32'h0000_FF00, 4'hF, 1, 0);
        do_read("R8 lock kept", A_LOCK, 1, 0);
        do_write("R8 priv lock", A_LOCK, 32'hFFFF_FF00, 4'hF, 1, 1);
        do_read("R8 R7 lock set", A_LOCK, 0, 0);
        // R4: unprivileged clear leaves locked bits
        do_write("R4 unpriv clear", A_SEC, 32'h0, 4'hF, 1, 0);
        do_write("R3 priv clear", A_SEC, 32'h0, 4'hF, 1, 1);
        // R2: non-secure write changes nothing, sets flag
        do_write("R2 nonsec sec", A_SEC, 32'h0001_FFFF, 4'hF, 0, 1);
        do_write("R2 nonsec lock", A_LOCK, 32'h0, 4'hF, 0, 1);
        // R9: flag sticky against other writes
        do_write("R9 unpriv clr", A_STAT, 32'h1, 4'hF, 1, 0);
        do_write("R9 priv zero", A_STAT, 32'h0, 4'hF, 1, 1);
        do_read("R9 flag held", A_STAT, 0, 0);
        do_write("R9 priv clr", A_STAT, 32'h1, 4'hF, 1, 1);
        // R6: partial strobes
        do_write("R6 partial", A_SEC, 32'h0001_FFFF, 4'h7, 1, 1);
        do_write("R6 partial lock", A_LOCK, 32'h0, 4'hE, 1, 1);
        do_read("R5 hole", A_HOLE, 1, 1);

        // Constrained random mix
        for (int i = 0; i < 600; i++) begin
            logic [11:0] a;
            logic [3:0]  s;
            case ($urandom_range(0, 7))
                0, 1, 2: a = A_SEC;
                3, 4:    a = A_LOCK;
                5, 6:    a = A_STAT;
                default: a = A_HOLE;
            endcase
            s = ($urandom_range(0, 5) == 0) ? 4'($urandom) : 4'hF;
            if ($urandom_range(0, 3) == 0)
                do_read("R5 rand", a, 1'($urandom), 1'($urandom));
            else
                do_write("R2 R3 R4 R6 R8 R9 rand", a, $urandom, s,
                         ($urandom_range(0, 4) != 0), 1'($urandom));
        end
        do_read("R7 final", A_SEC, 1, 1);

        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule